// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the synchronized input levels of one GPIO bank of up to 32 pins and turns qualifying pin activity into a single interrupt line for that bank. Each pin has its own trigger setup. It can be edge or level sensitive, it has a polarity, and it has a both-edges option. A detected event sets that pin's sticky status bit. A per-pin mask decides whether the status bit reaches the bank interrupt.

Software reaches the block through a simple register bus. Each access is a single-cycle write strobe with an address and data, and read data returns combinationally. The mask cannot be written directly. It is changed through two write-one command registers, one that unmasks and one that masks. Masking stops only propagation: detection goes on, so an event caught while masked raises the interrupt as soon as the pin is unmasked.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every mask bit is 1, and the status, trigger-type, polarity and both-edges registers are all 0. The byte offsets are: mask read 0x0C, unmask command 0x10, mask command 0x14, status 0x18, trigger type 0x1C, polarity 0x20, both-edges 0x24. Bit n of each register belongs to pin n.
- R2: A trigger-type bit of 1 makes the pin edge sensitive. A bit of 0 makes it level sensitive.
- R3: A polarity bit of 1 selects the rising edge or the high level. A polarity bit of 0 selects the falling edge or the low level.
- R4: In edge mode with the both-edges bit at 1, either edge sets status and polarity is ignored. In level mode the both-edges bit has no effect.
- R5: Writing 1 to a bit at 0x10 clears that pin's mask bit. Writing 1 to a bit at 0x14 sets that pin's mask bit. Zero bits in either write leave the mask unchanged.
- R6: A read at 0x0C returns 1 for every pin that is currently masked.
- R7: Status bits are sticky. A write to 0x18 clears the bits written as 1, and zero bits have no effect.
- R8: Status bits are still set while the pin is masked. Unmasking a pin whose status is set raises the interrupt in the same cycle that the mask changes.
- R9: The interrupt output is 1 exactly while some pin has its status bit at 1 and its mask bit at 0.
- R10: In level mode the status bit is set again on every clock while the active level persists, so a clear during the active level has no lasting effect.
- R11: Edges are found by comparing each input with its value one clock earlier. If a status clear and a new event hit the same pin in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Synchronized pin levels |
| irq | output | 1 | Bank interrupt |

## Verification
Two functions can act on a status bit in the same clock: a software clear written to the status register, and a fresh event from pin detection. The bench provokes this on purpose. In one test the clear write and a rising edge on an edge-triggered pin are applied at the same falling clock edge. In another, a clear is written while a level-triggered pin holds its active level. In both cases the status bit read back afterwards must still be 1. In a separate test, where no event coincides with the clear, the bit must read 0, which shows that the clear itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  // Byte offsets inside the bank window; software decodes these.
  localparam logic [BUS_AW-1:0] OFS_MASK_RD  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_UNMASK   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_MASKSET  = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_STATUS   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_TRIGTYPE = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_POLARITY = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_BOTHEDGE = 8'h24;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  trig_edge_o,
  output logic [NPINS-1:0]  pol_hi_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o
);

  logic [NPINS-1:0] trig_q, trig_d;
  logic [NPINS-1:0] pol_q, pol_d;
  logic [NPINS-1:0] both_q, both_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic             en_trig, en_pol, en_both, en_unmask, en_maskset;

  assign en_trig    = wr_i && (addr_i == OFS_TRIGTYPE);
  assign en_pol     = wr_i && (addr_i == OFS_POLARITY);
  assign en_both    = wr_i && (addr_i == OFS_BOTHEDGE);
  assign en_unmask  = wr_i && (addr_i == OFS_UNMASK);
  assign en_maskset = wr_i && (addr_i == OFS_MASKSET);

  always_comb begin
    trig_d = trig_q;
    pol_d  = pol_q;
    both_d = both_q;
    mask_d = mask_q;
    if (en_trig)    trig_d = wdata_i;
    if (en_pol)     pol_d  = wdata_i;
    if (en_both)    both_d = wdata_i;
    if (en_unmask)  mask_d = mask_q & ~wdata_i;
    if (en_maskset) mask_d = mask_q | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
      mask_q <= '1;
    end else begin
      trig_q <= trig_d;
      pol_q  <= pol_d;
      both_q <= both_d;
      mask_q <= mask_d;
    end
  end

  assign trig_edge_o = trig_q;
  assign pol_hi_o    = pol_q;
  assign both_o      = both_q;
  assign mask_o      = mask_q;
  assign clr_o       = (wr_i && (addr_i == OFS_STATUS)) ? wdata_i : '0;

  // Unmask command clears every written-one bit
  assert_unmask_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_unmask |=> ((mask_q & $past(wdata_i)) == '0));

  // Mask command sets every written-one bit
  assert_maskset_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_maskset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // Zero bits of either command leave the mask alone
  assert_zero_bits_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_unmask || en_maskset) |=>
      ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i))));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] trig_edge_i,
  input  logic [NPINS-1:0] pol_hi_i,
  input  logic [NPINS-1:0] both_i,
  output logic [NPINS-1:0] event_o
);

  logic [NPINS-1:0] prev_q, prev_d;

  assign prev_d = pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, lvl;
    assign rise = pin_i[g] & ~prev_q[g];
    assign fall = ~pin_i[g] & prev_q[g];
    assign lvl  = pol_hi_i[g] ? pin_i[g] : ~pin_i[g];
    assign event_o[g] = trig_edge_i[g]
                        ? (both_i[g] ? (rise | fall) : (pol_hi_i[g] ? rise : fall))
                        : lvl;
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);

  logic [NPINS-1:0] stat_q, stat_d;

  // New events take priority over a clear in the same cycle.
  always_comb begin
    stat_d = (stat_q & ~clr_i) | event_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & ~mask_i);

  // Every event, masked or not, lands in status
  assert_event_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(event_i)) == $past(event_i)));

  // A clear without a coinciding event leaves the bit at 0
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_i & ~event_i)) == '0));

  // Bits neither cleared nor hit stay as they were
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(~clr_i & ~event_i)) == ($past(stat_q) & $past(~clr_i & ~event_i))));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq
);

  logic [NPINS-1:0] trig_w, pol_w, both_w, mask_w, clr_w, event_w, stat_w;
  logic [NPINS-1:0] rd_pins;

  gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (bus_wr),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata[NPINS-1:0]),
    .trig_edge_o (trig_w),
    .pol_hi_o    (pol_w),
    .both_o      (both_w),
    .mask_o      (mask_w),
    .clr_o       (clr_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_in),
    .trig_edge_i (trig_w),
    .pol_hi_i    (pol_w),
    .both_i      (both_w),
    .event_o     (event_w)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (event_w),
    .clr_i    (clr_w),
    .mask_i   (mask_w),
    .status_o (stat_w),
    .irq_o    (irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_MASK_RD:  rd_pins = mask_w;
      OFS_STATUS:   rd_pins = stat_w;
      OFS_TRIGTYPE: rd_pins = trig_w;
      OFS_POLARITY: rd_pins = pol_w;
      OFS_BOTHEDGE: rd_pins = both_w;
      default:      rd_pins = '0;
    endcase
  end

  assign bus_rdata = BUS_DW'(rd_pins);

  // With every pin masked the bank stays quiet
  assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_w) |-> !irq);

  // An interrupt always has a latched status behind it
  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_w != '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam logic [7:0] A_MASK = 8'h0C, A_UNM = 8'h10, A_MSET = 8'h14,
                         A_STAT = 8'h18, A_TYPE = 8'h1C, A_POL = 8'h20, A_BOTH = 8'h24;

  // {type, pol, both, pin_before, pin_after, expected status}
  localparam int NVEC = 11;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110011, 6'b110100, 6'b100101, 6'b100010, 6'b101011, 6'b111101,
    6'b111110, 6'b010011, 6'b010000, 6'b000101, 6'b001110
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;
  logic [31:0] v;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPINS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    rd(A_STAT, v); check("R1 status in reset", v, 32'h0);
    rd(A_MASK, v); check("R1 mask after reset", v, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_TYPE, v); check("R1 type after reset", v, 32'h0);
    rd(A_POL,  v); check("R1 polarity after reset", v, 32'h0);
    rd(A_BOTH, v); check("R1 both-edges after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 R3 R4: trigger configurations on pin 0
    for (int i = 0; i < NVEC; i++) begin
      pin_in[0] = VEC[i][2];
      wr(A_TYPE, {31'h0, VEC[i][5]});
      wr(A_POL,  {31'h0, VEC[i][4]});
      wr(A_BOTH, {31'h0, VEC[i][3]});
      wr(A_STAT, 32'h1);
      @(negedge clk);
      pin_in[0] = VEC[i][1];
      @(negedge clk);
      rd(A_STAT, v);
      check($sformatf("R2 R3 R4 vector %0d", i), {31'h0, v[0]}, {31'h0, VEC[i][0]});
    end

    // Pin 0: rising edge, masked
    wr(A_TYPE, 32'h1); wr(A_POL, 32'h1); wr(A_BOTH, 32'h0);
    pin_in[0] = 1'b0;
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R7 cleared bit", {31'h0, v[0]}, 32'h0);
    pin_in[0] = 1'b1;
    @(negedge clk);
    rd(A_STAT, v); check("R8 status set while masked", {31'h0, v[0]}, 32'h1);
    check("R8 irq held while masked", {31'h0, irq}, 32'h0);
    wr(A_UNM, 32'h1);
    check("R8 irq on unmask", {31'h0, irq}, 32'h1);
    rd(A_MASK, v); check("R6 mask readback", v, 32'hFFFF_FFFE);
    wr(A_UNM, 32'h0);
    rd(A_MASK, v); check("R5 zero unmask bits", v, 32'hFFFF_FFFE);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R7 zero clear bits", {31'h0, v[0]}, 32'h1);
    wr(A_STAT, 32'h1);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    pin_in[0] = 1'b0;
    @(negedge clk);
    check("R9 no irq on wrong edge", {31'h0, irq}, 32'h0);
    pin_in[0] = 1'b1;
    @(negedge clk);
    check("R9 irq on unmasked event", {31'h0, irq}, 32'h1);
    wr(A_MSET, 32'h1);
    check("R5 mask command hides irq", {31'h0, irq}, 32'h0);
    rd(A_MASK, v); check("R5 mask command readback", v, 32'hFFFF_FFFF);
    wr(A_UNM, 32'h1);
    check("R9 irq back after unmask", {31'h0, irq}, 32'h1);

    // R11: clear and rising edge in the same cycle
    pin_in[0] = 1'b0;
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R11 precondition cleared", {31'h0, v[0]}, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1; pin_in[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_STAT, v); check("R11 event beats clear", {31'h0, v[0]}, 32'h1);

    // R10: level high held through a clear
    wr(A_TYPE, 32'h0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R10 level re-sets after clear", {31'h0, v[0]}, 32'h1);
    check("R10 irq persists on level", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule